// File: doc/BRIEF.md
# CAN Bit Sampler with Edge Resynchronisation

This block turns an oversampled single-wire CAN receive line into a stream of bit decisions. A sample-rate enable marks the clocks on which the line is looked at. Two static configuration inputs set the nominal bit time in samples (`bit_len`) and the position of the decision point inside that bit (`spt_ofs`). Both are plain integers, so software does the division of sample rate by bitrate (for example 1 Mbit/s) and works out the sample-point percentage (for example 70 %) before it programs them.

The control is a two-state machine. In `ST_IDLE` the block ignores recessive samples. On the first dominant enabled sample it takes the *start-detect* transition to `ST_RECV`. That sample becomes sample index 0, the start of frame and the first timing anchor. In `ST_RECV` every decision point is projected from the latest anchor as `anchor_sample + bit_len * (n - anchor_count) + spt_ofs`. Here `n` is the raw bit number, which counts every bit including stuff bits. Each recessive-to-dominant edge moves the anchor to that sample and to the current bit count. The *frame-end* transition back to `ST_IDLE` is taken when a frame parser downstream pulses `frame_done`. A synchronous `rst` also forces `ST_IDLE` from any state.

Each decision produces a one-clock strobe together with the sampled level and the raw bit number. A parser downstream does destuffing and field decoding.

Top module: `can_bit_sampler`

## Requirements
- R1: While `rst` is high and in the first clock after it, `bit_vld` is 0, `bit_val` is 1 and `bit_idx` is 0.
- R2: In idle, enabled samples at 1 (recessive) have no effect. The first enabled sample at 0 (dominant) starts reception and counts as sample index 0 with anchor bit count 0.
- R3: Bit n is decided at sample index anchor + `bit_len`·(n − anchor count) + `spt_ofs`, counted in enabled samples. Bit 0 is decided `spt_ofs` samples after the start sample. Valid settings are `bit_len` ≥ 2 and 1 ≤ `spt_ofs` < `bit_len`.
- R4: With no falling edge, consecutive decision points are exactly `bit_len` enabled samples apart.
- R5: In reception, a falling edge re-anchors the timing. A falling edge is an enabled sample at 0 whose previous enabled sample was 1. The next decision then falls `spt_ofs` samples after the edge sample.
- R6: If a falling edge lands on a decision point, the bit is decided from that sample first. The anchor then takes the incremented bit count, so the next decision comes `spt_ofs` samples after that sample.
- R7: `bit_idx` is 0 for the first bit after a start and rises by one per strobe. Every bit is counted, stuff bits included.
- R8: Clocks with `smp_en` low change nothing. They produce no strobe, do not advance the sample count and do not change `bit_val` or `bit_idx`.
- R9: A `frame_done` pulse returns the block to idle. It wins over a decision point in the same clock. No strobe follows until a new dominant start, and after that start `bit_idx` begins again at 0.
- R10: A synchronous reset in the middle of a frame stops reception in the same way. Reception restarts only on a new dominant sample.
- R11: `bit_vld` is high for the one clock after the clock that took the decision sample. Between strobes `bit_val` and `bit_idx` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample-rate enable; the line is sampled when high |
| rx_in | input | 1 | Bus receive level, 0 dominant, 1 recessive |
| bit_len | input | LW (8) | Nominal bit time in samples |
| spt_ofs | input | LW (8) | Decision point offset in samples within a bit |
| frame_done | input | 1 | One-clock pulse from the frame parser returning the block to idle |
| bit_vld | output | 1 | One-clock strobe per decided bit |
| bit_val | output | 1 | Level decided for the strobed bit |
| bit_idx | output | IW (8) | Raw bit number of the strobed bit, 0 at start of frame |

## Verification
A bit pattern with no falling edge after the start, run at two bit widths, pins down the plain projection from the start sample. The slower of these two runs spaces its samples with disabled clocks, which shows that only enabled samples are counted. A stream whose real bit time is 11 samples against a nominal 10, with alternating levels, gives decision points that match only if each falling edge re-anchors the timing. A stream with an edge exactly on a decision point separates the chosen ordering (sample first, then re-anchor with the new count) from the ordering where the edge takes effect first. Runs cut short by `frame_done` and by reset, followed by an all-recessive stretch and a fresh start, check the return to idle and the restart of the bit number.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RECV = 1'b1
    } cbs_state_e;

endpackage

// File: rtl/cbs_edge_det.sv
module cbs_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic smp_en,
    input  logic rx_in,
    output logic fall_o
);

    // level of the previous enabled sample; the bus idles recessive
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
        end else if (smp_en) begin
            prev_q <= rx_in;
        end
    end

    assign fall_o = smp_en & prev_q & ~rx_in;

    // two falling edges can never be seen on back-to-back clocks
    p_single_fall_r5: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/cbs_phase_track.sv
module cbs_phase_track #(
    parameter int SW = 16,
    parameter int LW = 8,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          recv_i,
    input  logic          smp_en,
    input  logic          fall_i,
    input  logic [LW-1:0] bit_len,
    input  logic [LW-1:0] spt_ofs,
    output logic          hit_o,
    output logic [IW-1:0] bcnt_o
);

    localparam int PW = LW + IW;

    logic [SW-1:0] scnt_q;      // index of the last processed sample
    logic [SW-1:0] anc_samp_q;  // sample index of the latest anchor
    logic [IW-1:0] anc_cnt_q;   // bit count at the latest anchor
    logic [IW-1:0] bcnt_q;      // bits decided so far

    logic [SW-1:0] cur_idx;
    logic [IW-1:0] span;
    logic [PW-1:0] prod;
    logic [SW-1:0] proj;

    always_comb begin
        cur_idx = scnt_q + SW'(1);
        span    = bcnt_q - anc_cnt_q;
        prod    = PW'(bit_len) * PW'(span);
        proj    = anc_samp_q + SW'(prod) + SW'(spt_ofs);
        hit_o   = recv_i & smp_en & (cur_idx == proj);
    end

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            scnt_q     <= '0;
            anc_samp_q <= '0;
            anc_cnt_q  <= '0;
            bcnt_q     <= '0;
        end else if (recv_i && smp_en) begin
            scnt_q <= cur_idx;
            if (hit_o) begin
                bcnt_q <= bcnt_q + IW'(1);
            end
            if (fall_i) begin
                // the decision of this sample is taken before re-anchoring
                anc_samp_q <= cur_idx;
                anc_cnt_q  <= hit_o ? (bcnt_q + IW'(1)) : bcnt_q;
            end
        end
    end

    assign bcnt_o = bcnt_q;

    // without an edge the projection advances by one bit time per decision
    p_step_bit_len_r4: assert property (@(posedge clk) disable iff (rst)
        (recv_i && hit_o && !fall_i) |=>
            (proj == $past(proj) + SW'(bit_len)) || !$stable(bit_len));

    // after an edge the next decision lies one offset past the edge sample
    p_resync_ofs_r5: assert property (@(posedge clk) disable iff (rst)
        (recv_i && fall_i) |=>
            (proj == $past(cur_idx) + SW'(spt_ofs)) || !$stable(spt_ofs));

endmodule

// File: rtl/cbs_bit_out.sv
module cbs_bit_out #(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit_i,
    input  logic          rx_in,
    input  logic [IW-1:0] idx_i,
    output logic          bit_vld,
    output logic          bit_val,
    output logic [IW-1:0] bit_idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_vld <= 1'b0;
            bit_val <= 1'b1;
            bit_idx <= '0;
        end else begin
            bit_vld <= hit_i;
            if (hit_i) begin
                bit_val <= rx_in;
                bit_idx <= idx_i;
            end
        end
    end

endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler #(
    parameter int LW = 8,
    parameter int IW = 8,
    parameter int SW = LW + IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_en,
    input  logic          rx_in,
    input  logic [LW-1:0] bit_len,
    input  logic [LW-1:0] spt_ofs,
    input  logic          frame_done,
    output logic          bit_vld,
    output logic          bit_val,
    output logic [IW-1:0] bit_idx
);

    import cbs_pkg::*;

    cbs_state_e    state_q, state_d;
    logic          start_w;
    logic          recv_w;
    logic          fall_w;
    logic          hit_w;
    logic [IW-1:0] bcnt_w;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: start-detect and frame-end
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!frame_done && smp_en && !rx_in) state_d = ST_RECV;
            ST_RECV: if (frame_done)                      state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // per-state control outputs
    always_comb begin
        start_w = 1'b0;
        recv_w  = 1'b0;
        unique case (state_q)
            ST_IDLE: start_w = !frame_done && smp_en && !rx_in;
            ST_RECV: recv_w  = !frame_done;
            default: begin
                start_w = 1'b0;
                recv_w  = 1'b0;
            end
        endcase
    end

    cbs_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .smp_en (smp_en),
        .rx_in  (rx_in),
        .fall_o (fall_w)
    );

    cbs_phase_track #(.SW(SW), .LW(LW), .IW(IW)) u_track (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_w),
        .recv_i  (recv_w),
        .smp_en  (smp_en),
        .fall_i  (fall_w),
        .bit_len (bit_len),
        .spt_ofs (spt_ofs),
        .hit_o   (hit_w),
        .bcnt_o  (bcnt_w)
    );

    cbs_bit_out #(.IW(IW)) u_out (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (hit_w),
        .rx_in   (rx_in),
        .idx_i   (bcnt_w),
        .bit_vld (bit_vld),
        .bit_val (bit_val),
        .bit_idx (bit_idx)
    );

    p_start_recv_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && smp_en && !rx_in && !frame_done) |=> (state_q == ST_RECV));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (state_q == ST_IDLE) && !bit_vld);

    p_no_en_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> !bit_vld);

    p_hold_outputs_r11: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> $stable(bit_idx) && $stable(bit_val));

endmodule

// File: tb/can_bit_sampler_bench.sv
module can_bit_sampler_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_en = 1'b0;
    logic       rx_in = 1'b1;
    logic [7:0] bit_len = 8'd10;
    logic [7:0] spt_ofs = 8'd7;
    logic       frame_done = 1'b0;
    logic       bit_vld;
    logic       bit_val;
    logic [7:0] bit_idx;

    always #5 clk = ~clk;

    can_bit_sampler u_can_bit_sampler (
        .clk        (clk),
        .rst        (rst),
        .smp_en     (smp_en),
        .rx_in      (rx_in),
        .bit_len    (bit_len),
        .spt_ofs    (spt_ofs),
        .frame_done (frame_done),
        .bit_vld    (bit_vld),
        .bit_val    (bit_val),
        .bit_idx    (bit_idx)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic strm [0:511];
    int   exp_pos [0:31];
    logic exp_val [0:31];
    int   exp_n;
    int   obs_pos [0:31];
    logic obs_val [0:31];
    int   obs_idx [0:31];
    int   obs_n;
    int   cur_k;
    int   hold_err;
    logic last_val;
    int   last_idx;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    // one clock, observed at the falling edge
    task automatic tick_obs();
        @(negedge clk);
        if (bit_vld) begin
            if (obs_n < 32) begin
                obs_pos[obs_n] = cur_k;
                obs_val[obs_n] = bit_val;
                obs_idx[obs_n] = int'(bit_idx);
            end
            obs_n++;
        end else if (bit_val !== last_val || int'(bit_idx) != last_idx) begin
            hold_err++;
        end
        last_val = bit_val;
        last_idx = int'(bit_idx);
    endtask

    task automatic play(input int n, input int gap);
        obs_n    = 0;
        hold_err = 0;
        for (int k = 0; k < n; k++) begin
            tick_obs();
            rx_in  = strm[k];
            smp_en = 1'b1;
            cur_k  = k;
            for (int g = 0; g < gap; g++) begin
                tick_obs();
                smp_en = 1'b0;
            end
        end
        tick_obs();
        smp_en = 1'b0;
        tick_obs();
    endtask

    task automatic compare(input string req);
        chk(obs_n == exp_n, req, "strobe count", obs_n, exp_n);
        for (int i = 0; i < exp_n && i < obs_n; i++) begin
            chk(obs_pos[i] == exp_pos[i], req, "decision sample", obs_pos[i], exp_pos[i]);
            chk(obs_val[i] == exp_val[i], req, "bit value", int'(obs_val[i]), int'(exp_val[i]));
            chk(obs_idx[i] == i, "R7", "bit index", obs_idx[i], i);
        end
        chk(hold_err == 0, "R11", "outputs changed without strobe", hold_err, 0);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        smp_en     = 1'b0;
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        last_val = bit_val;
        last_idx = int'(bit_idx);
    endtask

    task automatic do_reset();
        @(negedge clk);
        smp_en = 1'b0;
        rst    = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(bit_vld == 1'b0, "R1", "bit_vld in reset", int'(bit_vld), 0);
        chk(bit_val == 1'b1, "R1", "bit_val in reset", int'(bit_val), 1);
        chk(bit_idx == 8'd0, "R1", "bit_idx in reset", int'(bit_idx), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(bit_vld == 1'b0 && bit_idx == 8'd0, "R1", "state after reset",
            int'(bit_idx), 0);
        last_val = bit_val;
        last_idx = int'(bit_idx);
    endtask

    // R2 R3 R4: no falling edge after the start; R8 when gap > 0
    task automatic t_plain(input int bl, input int ofs, input int idle, input int gap,
                           input string req);
        int pat [0:6] = '{0, 0, 0, 1, 1, 1, 1};
        int total;
        bit_len = 8'(bl);
        spt_ofs = 8'(ofs);
        total = idle + 7 * bl;
        for (int k = 0; k < total; k++)
            strm[k] = (k < idle) ? 1'b1 : 1'(pat[(k - idle) / bl]);
        exp_n = 7;
        for (int i = 0; i < 7; i++) begin
            exp_pos[i] = idle + ofs + bl * i;
            exp_val[i] = 1'(pat[i]);
        end
        play(total, gap);
        compare(req);
        pulse_done();
    endtask

    // R5: real bit time 11 samples, nominal 10, alternating levels
    task automatic t_drift();
        int ep [0:6] = '{10, 20, 32, 42, 54, 64, 74};
        int ev [0:6] = '{0, 1, 0, 1, 0, 1, 1};
        bit_len = 8'd10;
        spt_ofs = 8'd7;
        for (int k = 0; k < 80; k++) begin
            if (k < 3 || k >= 69) strm[k] = 1'b1;
            else                  strm[k] = 1'(((k - 3) / 11) % 2);
        end
        exp_n = 7;
        for (int i = 0; i < 7; i++) begin
            exp_pos[i] = ep[i];
            exp_val[i] = 1'(ev[i]);
        end
        play(80, 0);
        compare("R5");
        pulse_done();
    endtask

    // R6: falling edge on the decision sample of bit 1
    task automatic t_coincide();
        int ep [0:3] = '{9, 19, 26, 36};
        int ev [0:3] = '{1, 0, 0, 0};
        bit_len = 8'd10;
        spt_ofs = 8'd7;
        for (int k = 0; k < 40; k++)
            strm[k] = (k < 2 || (k >= 5 && k < 19)) ? 1'b1 : 1'b0;
        exp_n = 4;
        for (int i = 0; i < 4; i++) begin
            exp_pos[i] = ep[i];
            exp_val[i] = 1'(ev[i]);
        end
        play(40, 0);
        compare("R6");
        pulse_done();
    endtask

    task automatic restart_frame(input string req);
        for (int k = 0; k < 23; k++) strm[k] = (k < 3) ? 1'b1 : 1'b0;
        exp_n = 2;
        exp_pos[0] = 10; exp_val[0] = 1'b0;
        exp_pos[1] = 20; exp_val[1] = 1'b0;
        play(23, 0);
        compare(req);
    endtask

    // R9: frame_done ends reception; silence; restart from index 0
    task automatic t_done();
        bit_len = 8'd10;
        spt_ofs = 8'd7;
        for (int k = 0; k < 30; k++) strm[k] = 1'b0;
        exp_n = 3;
        for (int i = 0; i < 3; i++) begin
            exp_pos[i] = 7 + 10 * i;
            exp_val[i] = 1'b0;
        end
        play(30, 0);
        compare("R9");
        pulse_done();
        for (int k = 0; k < 40; k++) strm[k] = 1'b1;
        play(40, 0);
        chk(obs_n == 0, "R9", "strobes after frame_done", obs_n, 0);
        restart_frame("R9");
        pulse_done();
    endtask

    // R10: reset in the middle of a frame
    task automatic t_rst_mid();
        bit_len = 8'd10;
        spt_ofs = 8'd7;
        for (int k = 0; k < 25; k++) strm[k] = 1'b0;
        exp_n = 2;
        exp_pos[0] = 7;  exp_val[0] = 1'b0;
        exp_pos[1] = 17; exp_val[1] = 1'b0;
        play(25, 0);
        compare("R10");
        do_reset();
        for (int k = 0; k < 30; k++) strm[k] = 1'b1;
        play(30, 0);
        chk(obs_n == 0, "R10", "strobes after reset", obs_n, 0);
        restart_frame("R10");
        pulse_done();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, got 0 expected 1");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        cur_k    = 0;
        hold_err = 0;
        last_val = 1'b1;
        last_idx = 0;
        do_reset();
        t_plain(10, 7, 5, 0, "R3");
        t_plain(25, 17, 3, 2, "R8");
        t_drift();
        t_coincide();
        t_done();
        t_rst_mid();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule